// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, A and B, and moves data between them in either direction. Each direction has its own storage register and its own capture clock. A per-direction select picks what the far port is driven with. It is either the live value now on the near bus or the value held in that direction's register. Two output enables decide which ports are actively driven. The enable for the B port is active high. The enable for the A port is active low.

Each bus pin is modelled as three signals: the value applied from outside together with a flag saying whether an outside driver is active, an internal drive value, and an internal drive enable. No tri-state buffer is needed. Every bus has a single resolved value. A bus that nobody drives keeps its last driven value through a per-bus keeper.

The capture clocks are sampled on the system clock. A capture takes place in the system-clock cycle in which a capture clock is first seen high after being low. Capture always happens, whatever the selects and enables are set to. This makes it possible to store either bus into both registers, or to store both buses while the ports stay isolated.

Top module: `regbus_xcvr`

## Requirements
- R1: A synchronous reset, `rst` high at a rising `clk` edge, clears both storage registers and both keeper values to zero. With nothing driving, both resolved buses then read zero.
- R2: At a `clk` edge where `ab_clk` is high and was low at the previous edge, the A-to-B register loads the resolved A bus value. This happens regardless of enables and selects.
- R3: At a `clk` edge where `ba_clk` is high and was low at the previous edge, the B-to-A register loads the resolved B bus value. This happens regardless of enables and selects.
- R4: `b_oe` follows `ab_oe`, which is active high. `a_oe` is the inverse of `ba_oe_n`, which is active low. An output that is not enabled presents zero.
- R5: While port B is enabled, `ab_sel`=0 drives B with the resolved A value and `ab_sel`=1 drives B with the A-to-B register.
- R6: While port A is enabled, `ba_sel`=0 drives A with the resolved B value and `ba_sel`=1 drives A with the B-to-A register.
- R7: A bus resolves to its internal drive value when its port is enabled. Otherwise it resolves to the outside value when `*_ext` is 1. Otherwise it resolves to its keeper value.
- R8: The keeper of a bus takes the resolved value at every `clk` edge where that bus is driven, either from inside or from outside. When the bus is undriven, the keeper keeps its value.
- R9: With both ports enabled and both selects live, the two buses form one net. Its value is `a_in` if A is driven from outside, else `b_in` if B is driven from outside, else the A keeper value. When all outside drivers release, both buses keep their last value.
- R10: `a_clash` or `b_clash` is 1 in a cycle where that port is enabled, its outside driver is active, and the outside value differs from the resolved bus value.
- R11: While B is driven live from A, a B-to-A capture stores the A data, so both registers can hold the A value. The mirror case, with A driven live from B, holds as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ab_clk | input | 1 | Capture clock of the A-to-B register |
| ba_clk | input | 1 | Capture clock of the B-to-A register |
| ab_oe | input | 1 | Enable for driving port B, active high |
| ba_oe_n | input | 1 | Enable for driving port A, active low |
| ab_sel | input | 1 | B source: 0 live A, 1 stored |
| ba_sel | input | 1 | A source: 0 live B, 1 stored |
| a_in | input | W | Value applied to bus A from outside |
| a_ext | input | 1 | Outside driver on A is active |
| a_out | output | W | Internal drive value for A |
| a_oe | output | 1 | Internal driver on A is active |
| a_bus | output | W | Resolved value of bus A |
| a_clash | output | 1 | Contention on A |
| b_in | input | W | Value applied to bus B from outside |
| b_ext | input | 1 | Outside driver on B is active |
| b_out | output | W | Internal drive value for B |
| b_oe | output | 1 | Internal driver on B is active |
| b_bus | output | W | Resolved value of bus B |
| b_clash | output | 1 | Contention on B |

## Verification
The bench builds the block at its default width of W=8. At that width, random bus values make a false match between the two drivers in a contention check unlikely. The full cross of enables, selects, outside-driver flags and capture-clock levels is also covered many times over in a few thousand cycles. The loop mode, isolation with storage, and both-register capture all come up often under random stimulus, and directed sequences pin down their exact order.

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ab_clk,
  input  logic         ba_clk,
  input  logic         ab_oe,
  input  logic         ba_oe_n,
  input  logic         ab_sel,
  input  logic         ba_sel,
  input  logic [W-1:0] a_in,
  input  logic         a_ext,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] a_bus,
  output logic         a_clash,
  input  logic [W-1:0] b_in,
  input  logic         b_ext,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  output logic [W-1:0] b_bus,
  output logic         b_clash
);

  logic [W-1:0] reg_ab, reg_ba, hold_a, hold_b;
  logic [W-1:0] live_a, live_b, base_a, base_b, net;
  logic         ab_clk_q, ba_clk_q;
  logic         drv_a, drv_b, a_from_b, b_from_a, loop_mode;

  assign drv_a = ~ba_oe_n;
  assign drv_b = ab_oe;

  assign live_a = a_ext ? a_in : hold_a;
  assign live_b = b_ext ? b_in : hold_b;

  assign base_a = drv_a ? reg_ba : live_a;
  assign base_b = drv_b ? reg_ab : live_b;

  assign a_from_b  = drv_a & ~ba_sel;
  assign b_from_a  = drv_b & ~ab_sel;
  assign loop_mode = a_from_b & b_from_a;

  assign net = a_ext ? a_in : (b_ext ? b_in : hold_a);

  always_comb begin
    if (loop_mode) begin
      a_bus = net;
      b_bus = net;
    end else begin
      a_bus = a_from_b ? base_b : base_a;
      b_bus = b_from_a ? base_a : base_b;
    end
  end

  assign a_oe    = drv_a;
  assign b_oe    = drv_b;
  assign a_out   = drv_a ? a_bus : '0;
  assign b_out   = drv_b ? b_bus : '0;
  assign a_clash = drv_a & a_ext & (a_in != a_bus);
  assign b_clash = drv_b & b_ext & (b_in != b_bus);

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_ab   <= '0;
      reg_ba   <= '0;
      hold_a   <= '0;
      hold_b   <= '0;
      ab_clk_q <= ab_clk;
      ba_clk_q <= ba_clk;
    end else begin
      ab_clk_q <= ab_clk;
      ba_clk_q <= ba_clk;
      if (ab_clk && !ab_clk_q) reg_ab <= a_bus;
      if (ba_clk && !ba_clk_q) reg_ba <= b_bus;
      if (a_ext || drv_a) hold_a <= a_bus;
      if (b_ext || drv_b) hold_b <= b_bus;
    end
  end

  // R2
  ab_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (ab_clk && !ab_clk_q) |=> (reg_ab == $past(a_bus)));

  // R3
  ba_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (ba_clk && !ba_clk_q) |=> (reg_ba == $past(b_bus)));

  // R8
  hold_track_chk: assert property (@(posedge clk) disable iff (rst)
    (!a_ext && !a_oe) |=> (hold_a == $past(hold_a)));

  // R9
  loop_join_chk: assert property (@(posedge clk) disable iff (rst)
    (a_oe && b_oe && !ab_sel && !ba_sel) |-> (a_bus == b_bus));

  // R5
  b_stored_chk: assert property (@(posedge clk) disable iff (rst)
    (ab_oe && ab_sel) |-> (b_out == reg_ab));

  // R10
  clash_src_chk: assert property (@(posedge clk) disable iff (rst)
    (a_clash || b_clash) |-> ((a_ext && a_oe) || (b_ext && b_oe)));

endmodule

// File: tb/regbus_xcvr_tb.sv
module regbus_xcvr_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst;
  logic ab_clk, ba_clk, ab_oe, ba_oe_n, ab_sel, ba_sel, a_ext, b_ext;
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] a_out, b_out, a_bus, b_bus;
  logic a_oe, b_oe, a_clash, b_clash;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [W-1:0] m_rab, m_rba, m_ha, m_hb, e_a, e_b;
  logic m_abq, m_baq;

  always #2.5 clk = ~clk;

  regbus_xcvr #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .ab_clk(ab_clk), .ba_clk(ba_clk),
    .ab_oe(ab_oe), .ba_oe_n(ba_oe_n), .ab_sel(ab_sel), .ba_sel(ba_sel),
    .a_in(a_in), .a_ext(a_ext), .a_out(a_out), .a_oe(a_oe),
    .a_bus(a_bus), .a_clash(a_clash),
    .b_in(b_in), .b_ext(b_ext), .b_out(b_out), .b_oe(b_oe),
    .b_bus(b_bus), .b_clash(b_clash)
  );

  function automatic logic [W-1:0] side_val(input logic ext, input logic [W-1:0] v,
                                            input logic [W-1:0] h);
    return ext ? v : h;
  endfunction

  function automatic logic [W-1:0] exp_bus_a();
    logic pa, pb;
    pa = !ba_oe_n;
    pb = ab_oe;
    if (!pa) return side_val(a_ext, a_in, m_ha);
    if (ba_sel) return m_rba;
    if (!pb) return side_val(b_ext, b_in, m_hb);
    if (ab_sel) return m_rab;
    return a_ext ? a_in : (b_ext ? b_in : m_ha);
  endfunction

  function automatic logic [W-1:0] exp_bus_b();
    logic pa, pb;
    pa = !ba_oe_n;
    pb = ab_oe;
    if (!pb) return side_val(b_ext, b_in, m_hb);
    if (ab_sel) return m_rab;
    if (!pa) return side_val(a_ext, a_in, m_ha);
    if (ba_sel) return m_rba;
    return a_ext ? a_in : (b_ext ? b_in : m_ha);
  endfunction

  task automatic chk(input string req, input string what, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    e_a = exp_bus_a();
    e_b = exp_bus_b();
    chk((ab_oe && !ba_oe_n && !ab_sel && !ba_sel) ? "R9" : "R7", "a_bus", a_bus, e_a);
    chk((ab_oe && !ba_oe_n && !ab_sel && !ba_sel) ? "R9" : "R7", "b_bus", b_bus, e_b);
    chk("R4", "a_oe", W'(a_oe), W'(!ba_oe_n));
    chk("R4", "b_oe", W'(b_oe), W'(ab_oe));
    chk(ba_sel ? "R3" : "R6", "a_out", a_out, !ba_oe_n ? e_a : '0);
    chk(ab_sel ? "R2" : "R5", "b_out", b_out, ab_oe ? e_b : '0);
    chk("R10", "a_clash", W'(a_clash), W'(!ba_oe_n && a_ext && (a_in != e_a)));
    chk("R10", "b_clash", W'(b_clash), W'(ab_oe && b_ext && (b_in != e_b)));
  endtask

  task automatic tick(input bit do_chk);
    #1;
    if (do_chk) check_all();
    e_a = exp_bus_a();
    e_b = exp_bus_b();
    @(posedge clk);
    if (rst) begin
      m_rab = '0; m_rba = '0; m_ha = '0; m_hb = '0;
    end else begin
      if (ab_clk && !m_abq) m_rab = e_a;
      if (ba_clk && !m_baq) m_rba = e_b;
      if (a_ext || !ba_oe_n) m_ha = e_a;
      if (b_ext || ab_oe) m_hb = e_b;
    end
    m_abq = ab_clk;
    m_baq = ba_clk;
    @(negedge clk);
  endtask

  task automatic idle();
    ab_clk = 0; ba_clk = 0; ab_oe = 0; ba_oe_n = 1; ab_sel = 0; ba_sel = 0;
    a_ext = 0; b_ext = 0; a_in = '0; b_in = '0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    m_rab = '0; m_rba = '0; m_ha = '0; m_hb = '0; m_abq = 0; m_baq = 0;
    rst = 1;
    @(negedge clk);
    tick(0); tick(0);
    rst = 0;
    // R1: reset state
    #1;
    chk("R1", "a_bus after reset", a_bus, '0);
    chk("R1", "b_bus after reset", b_bus, '0);
    ab_oe = 1; ab_sel = 1; ba_oe_n = 0; ba_sel = 1;
    #1;
    chk("R1", "stored A-to-B after reset", b_out, '0);
    chk("R1", "stored B-to-A after reset", a_out, '0);
    idle();
    tick(1);

    // R8: keeper after outside driver releases
    a_ext = 1; a_in = 8'h5A; tick(1);
    a_ext = 0; a_in = 8'hFF; #1;
    chk("R8", "A keeper after release", a_bus, 8'h5A);
    tick(1);

    // R11: A driven live onto B, B-to-A capture stores A data; also A-to-B capture
    ab_oe = 1; ab_sel = 0; a_ext = 1; a_in = 8'hC3; tick(1);
    ab_clk = 1; ba_clk = 1; tick(1);
    idle();
    ab_oe = 1; ab_sel = 1; ba_oe_n = 0; ba_sel = 1; #1;
    chk("R11", "B-to-A holds A data", a_out, 8'hC3);
    chk("R11", "A-to-B holds A data", b_out, 8'hC3);
    tick(1);

    // R2/R3: capture while isolated
    idle(); a_ext = 1; a_in = 8'h11; b_ext = 1; b_in = 8'h22; tick(1);
    ab_clk = 1; ba_clk = 1; tick(1);
    ab_clk = 1; ba_clk = 1; a_in = 8'h33; b_in = 8'h44; tick(1);
    idle(); ab_oe = 1; ab_sel = 1; ba_oe_n = 0; ba_sel = 1; #1;
    chk("R2", "isolated A capture", b_out, 8'h11);
    chk("R3", "isolated B capture", a_out, 8'h22);
    tick(1);

    // R9: loop mode keeps last value after release
    idle(); ab_oe = 1; ba_oe_n = 0; b_ext = 1; b_in = 8'h96; tick(1);
    b_ext = 0; b_in = 8'h00; tick(1); tick(1); #1;
    chk("R9", "loop A holds", a_bus, 8'h96);
    chk("R9", "loop B holds", b_bus, 8'h96);
    tick(1);

    // R10: contention on B
    idle(); ab_oe = 1; ab_sel = 0; a_ext = 1; a_in = 8'h0F; b_ext = 1; b_in = 8'hF0; #1;
    chk("R10", "b_clash on differing drivers", W'(b_clash), W'(1));
    tick(1);

    for (int i = 0; i < 4000; i++) begin
      ab_clk  = 1'($urandom);
      ba_clk  = 1'($urandom);
      ab_oe   = 1'($urandom);
      ba_oe_n = 1'($urandom);
      ab_sel  = 1'($urandom);
      ba_sel  = 1'($urandom);
      a_ext   = 1'($urandom);
      b_ext   = 1'($urandom);
      a_in    = W'($urandom);
      b_in    = W'($urandom);
      rst     = (($urandom % 500) == 0);
      tick(1);
    end
    rst = 0;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule